// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block holds one extra 256-byte identification page beside a serial memory's main array and handles the four instructions that act on it. These instructions read the page, program the page, report whether the page is locked, and lock it. The upstream serial front end does the shifting and opcode decode. It hands this block four things: the decoded instruction kind with its address at the start of a frame, each complete data byte as it arrives, a request for each byte to be shifted out, and a strobe at deselect. That strobe says whether the frame ended on a byte boundary. The write-enable latch state comes in from the status logic, and this block answers with a pulse that asks for the latch to be cleared.

The lock is one-time. After a lock instruction is accepted, the page can only be read. The page contents and the lock bit model non-volatile cells, so the synchronous reset leaves them alone. A separate erase input returns them to the delivery state, with every page byte at 0xFF and the page unlocked. Programming bytes are collected in a staging buffer and committed all at once at deselect. A rejected frame therefore leaves no trace.

Top module: `idpage_ctrl`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `rd_valid`, `page_wr_req`, `lock_prog_req` and `wel_clear` are 0.
- R2: A page read (`cmd_kind` = 2'b00) returns, one cycle after each `rd_req`, the byte at address bits [7:0]. Each further request returns the next byte, and the address wraps from 0xFF to 0x00. Address bits above bit 7 do not select the byte.
- R3: A page write (`cmd_kind` = 2'b01) with `wel` high and the page unlocked updates the page when deselect comes on a byte boundary after at least one data byte. The bytes are stored from address bits [7:0] upward, wrapping within the page. One cycle after `frame_end`, `page_wr_req` and `wel_clear` pulse for one cycle.
- R4: A page write with `wel` low at deselect leaves the page unchanged and raises no pulse.
- R5: A page write that ends off a byte boundary (`frame_aligned` = 0), or that carries no data byte, leaves the page unchanged and raises no pulse.
- R6: A lock-status read (`cmd_kind` = 2'b10) returns {7'b0, locked} when address bit 10 is 1, and 0x00 when address bit 10 is 0.
- R7: A lock instruction (`cmd_kind` = 2'b11) with `wel` high, address bit 10 set, at least one data byte and an aligned deselect sets the lock. One cycle after `frame_end`, `locked`, `lock_prog_req` and `wel_clear` are high.
- R8: A lock instruction with `wel` low, or with address bit 10 clear, is ignored: `locked` stays 0 and no pulse follows.
- R9: While locked, a complete page write or lock instruction is rejected. The page is unchanged, `page_wr_req` and `lock_prog_req` stay 0, and `wel_clear` pulses one cycle after `frame_end`.
- R10: The lock bit and the page contents survive `rst_n`. Only `nv_erase` clears the lock and sets every page byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of frame state and pulses |
| nv_erase | input | 1 | Returns page to 0xFF and clears the lock (delivery state) |
| cmd_start | input | 1 | Frame start pulse with decoded kind and address |
| cmd_kind | input | 2 | 00 read page, 01 write page, 10 read lock status, 11 lock |
| cmd_addr | input | 24 | Address received with the instruction |
| dat_valid | input | 1 | One complete data byte received |
| dat_byte | input | 8 | Received data byte |
| rd_req | input | 1 | Request for the next byte to shift out |
| frame_end | input | 1 | Deselect strobe |
| frame_aligned | input | 1 | Deselect came on a byte boundary |
| wel | input | 1 | Write-enable latch state |
| rd_valid | output | 1 | `rd_data` holds the requested byte |
| rd_data | output | 8 | Page byte or lock status byte |
| page_wr_req | output | 1 | Page program cycle requested |
| lock_prog_req | output | 1 | Lock program cycle requested |
| wel_clear | output | 1 | Request to clear the write-enable latch |
| locked | output | 1 | Page is permanently read-only |

## Verification
The assertions assume three things about the front end: `nv_erase` is held together with reset at power-on, so the lock cell has a defined value before the first check; `rd_req`, `dat_valid` and `frame_end` never share a cycle with `cmd_start`; and `frame_end` closes only a frame that `cmd_start` opened. The stimulus respects all three. Every input changes on the falling clock edge. Each frame is built from separate start, byte, request and deselect steps, and reset is always released with the erase already applied.

// File: rtl/idpage_pkg.sv
// Shared definitions for the identification page controller.
// Assumes the front end encodes instruction kinds as listed below.
package idpage_pkg;
    typedef enum logic [1:0] {
        KIND_RD_PAGE  = 2'b00,
        KIND_WR_PAGE  = 2'b01,
        KIND_RD_LOCK  = 2'b10,
        KIND_SET_LOCK = 2'b11
    } idp_kind_e;
endpackage

// File: rtl/idpage_frame.sv
// Frame tracker: records kind and lock-select address bit of the current
// frame and whether a whole data byte arrived. Assumes cmd_start and
// frame_end never coincide.
module idpage_frame #(
    parameter int ADDR_W  = 24,
    parameter int SEL_BIT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_start,
    input  idpage_pkg::idp_kind_e cmd_kind,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic                 dat_valid,
    input  logic                 frame_end,
    output logic                 active,
    output idpage_pkg::idp_kind_e kind_q,
    output logic                 sel_q,
    output logic                 byte_seen
);
    // Track frame open/close, kind, select bit and byte arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            kind_q    <= idpage_pkg::KIND_RD_PAGE;
            sel_q     <= 1'b0;
            byte_seen <= 1'b0;
        end else if (cmd_start) begin
            active    <= 1'b1;
            kind_q    <= cmd_kind;
            sel_q     <= cmd_addr[SEL_BIT];
            byte_seen <= 1'b0;
        end else begin
            if (frame_end) active <= 1'b0;
            if (dat_valid && active) byte_seen <= 1'b1;
        end
    end

    AST_NO_BYTE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cmd_start) |=> !byte_seen || $past(byte_seen)); // R5
endmodule

// File: rtl/idpage_lock_cell.sv
// One-time lock cell. Models a non-volatile bit: the functional reset does
// not touch it, only nv_erase clears it. Assumes nv_erase is applied at
// power-on.
module idpage_lock_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_erase,
    input  logic set_req,
    output logic locked
);
    // Set on an accepted lock, clear only on erase.
    always_ff @(posedge clk) begin
        if (nv_erase)     locked <= 1'b0;
        else if (set_req) locked <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !nv_erase) |=> locked); // R10
endmodule

// File: rtl/idpage_store.sv
// Page storage with a staging buffer. Bytes of a write frame go to the
// staging buffer and commit to the page in one cycle. Reads return the page
// byte at a pointer that wraps within the page, or the lock status byte.
// Assumes rd_go and wr_go never coincide with cmd_start.
module idpage_store #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_erase,
    input  logic              cmd_start,
    input  logic [PTR_W-1:0]  base_ptr,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              commit,
    input  logic              rd_go,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] status_byte,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] page_mem  [DEPTH];
    logic [DATA_W-1:0] stage_mem [DEPTH];
    logic [DEPTH-1:0]  stage_mask;
    logic [PTR_W-1:0]  cur_ptr;

    // Byte pointer: loaded at frame start, advanced per byte, wraps in page.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cur_ptr <= '0;
        else if (cmd_start)                   cur_ptr <= base_ptr;
        else if (wr_go || (rd_go && !rd_status)) cur_ptr <= cur_ptr + 1'b1;
    end

    // Staging buffer: collects write bytes of the open frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_start) begin
            stage_mask <= '0;
        end else if (wr_go) begin
            stage_mask[cur_ptr] <= 1'b1;
        end
        if (wr_go) stage_mem[cur_ptr] <= wr_byte;
    end

    // Page array: erased to all ones, updated only by a commit.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (nv_erase)                        page_mem[i] <= '1;
            else if (commit && stage_mask[i])    page_mem[i] <= stage_mem[i];
        end
    end

    // Read port: one byte per request, one cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= rd_status ? status_byte : page_mem[cur_ptr];
        end
    end

    AST_READ_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_go)); // R2
    AST_NO_COMMIT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !commit); // R3
endmodule

// File: rtl/idpage_ctrl.sv
// Lockable identification page controller (top). Decides at deselect
// whether a page write or lock instruction is accepted, rejected or ignored,
// and drives the program and latch-clear pulses one cycle later.
// Assumes decoded instruction input from a serial front end.
module idpage_ctrl #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int DATA_W     = 8,
    parameter int SEL_BIT    = 10,
    localparam int PTR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_erase,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_byte,
    input  logic              rd_req,
    input  logic              frame_end,
    input  logic              frame_aligned,
    input  logic              wel,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              page_wr_req,
    output logic              lock_prog_req,
    output logic              wel_clear,
    output logic              locked
);
    import idpage_pkg::*;

    idp_kind_e   kind_in, kind_q;
    logic        active, sel_q, byte_seen;
    logic        closing, do_commit, do_lock, do_clr;
    logic        wr_go, rd_go, rd_status;
    logic [DATA_W-1:0] status_byte;
    logic        addr_unused;

    assign kind_in     = idp_kind_e'(cmd_kind);
    assign addr_unused = ^cmd_addr;

    idpage_frame #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_kind  (kind_in),
        .cmd_addr  (cmd_addr),
        .dat_valid (dat_valid),
        .frame_end (frame_end),
        .active    (active),
        .kind_q    (kind_q),
        .sel_q     (sel_q),
        .byte_seen (byte_seen)
    );

    idpage_lock_cell u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_erase (nv_erase),
        .set_req  (do_lock),
        .locked   (locked)
    );

    // Route data bytes and read requests to the store by frame kind.
    always_comb begin
        wr_go       = dat_valid && active && (kind_q == KIND_WR_PAGE);
        rd_status   = (kind_q == KIND_RD_LOCK);
        rd_go       = rd_req && active &&
                      (kind_q == KIND_RD_PAGE || kind_q == KIND_RD_LOCK);
        status_byte = {{(DATA_W-1){1'b0}}, locked && sel_q};
    end

    idpage_store #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_erase    (nv_erase),
        .cmd_start   (cmd_start),
        .base_ptr    (cmd_addr[PTR_W-1:0]),
        .wr_go       (wr_go),
        .wr_byte     (dat_byte),
        .commit      (do_commit),
        .rd_go       (rd_go),
        .rd_status   (rd_status),
        .status_byte (status_byte),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    // Deselect decision: accept, reject on lock, or ignore.
    always_comb begin
        closing   = frame_end && active && frame_aligned && byte_seen;
        do_commit = 1'b0;
        do_lock   = 1'b0;
        do_clr    = 1'b0;
        if (closing) begin
            case (kind_q)
                KIND_WR_PAGE: begin
                    if (locked) begin
                        do_clr = 1'b1;
                    end else if (wel) begin
                        do_commit = 1'b1;
                        do_clr    = 1'b1;
                    end
                end
                KIND_SET_LOCK: begin
                    if (sel_q && locked) begin
                        do_clr = 1'b1;
                    end else if (sel_q && wel) begin
                        do_lock = 1'b1;
                        do_clr  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output pulses, one cycle after deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_wr_req   <= 1'b0;
            lock_prog_req <= 1'b0;
            wel_clear     <= 1'b0;
        end else begin
            page_wr_req   <= do_commit;
            lock_prog_req <= do_lock;
            wel_clear     <= do_clr;
        end
    end

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr_req |-> ($past(wel) && !$past(locked))); // R3
    AST_WRITE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr_req |-> wel_clear); // R3
    AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        lock_prog_req |-> (locked && !$past(locked) && $past(wel))); // R7
    AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) && !$past(nv_erase) |-> !page_wr_req && !lock_prog_req); // R9
    AST_ONE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({page_wr_req, lock_prog_req})); // R7
endmodule

// File: tb/test_idpage_ctrl.sv
`timescale 1ns/1ps
module test_idpage_ctrl;
    localparam logic [1:0] K_RDP = 2'b00, K_WRP = 2'b01, K_RDL = 2'b10, K_LCK = 2'b11;

    logic clk = 1'b0;
    logic rst_n, nv_erase, cmd_start, dat_valid, rd_req, frame_end, frame_aligned, wel;
    logic [1:0]  cmd_kind;
    logic [23:0] cmd_addr;
    logic [7:0]  dat_byte, rd_data;
    logic rd_valid, page_wr_req, lock_prog_req, wel_clear, locked;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [256];
    logic model_lock;

    always #4 clk = ~clk;

    idpage_ctrl i_idpage_ctrl (
        .clk(clk), .rst_n(rst_n), .nv_erase(nv_erase), .cmd_start(cmd_start),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .dat_valid(dat_valid),
        .dat_byte(dat_byte), .rd_req(rd_req), .frame_end(frame_end),
        .frame_aligned(frame_aligned), .wel(wel), .rd_valid(rd_valid),
        .rd_data(rd_data), .page_wr_req(page_wr_req), .lock_prog_req(lock_prog_req),
        .wel_clear(wel_clear), .locked(locked)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [1:0] k, input logic [23:0] a);
        @(negedge clk); cmd_start = 1'b1; cmd_kind = k; cmd_addr = a;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); dat_valid = 1'b1; dat_byte = b;
        @(negedge clk); dat_valid = 1'b0;
    endtask

    // Close the frame; pulses sampled one cycle after frame_end.
    task automatic end_frame(input logic aligned, input string tag,
                             input logic ewr, input logic elk, input logic eclr);
        @(negedge clk); frame_end = 1'b1; frame_aligned = aligned;
        @(negedge clk); frame_end = 1'b0;
        chk({tag, " page_wr_req"}, {7'b0, page_wr_req}, {7'b0, ewr});
        chk({tag, " lock_prog_req"}, {7'b0, lock_prog_req}, {7'b0, elk});
        chk({tag, " wel_clear"}, {7'b0, wel_clear}, {7'b0, eclr});
        @(negedge clk);
    endtask

    task automatic read_byte(input string tag, input logic [7:0] exp);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk({tag, " rd_valid"}, {7'b0, rd_valid}, 8'h01);
        chk(tag, rd_data, exp);
    endtask

    task automatic write_frame(input logic [23:0] a, input int n, input logic [7:0] seed,
                               input logic w, input string tag,
                               input logic ewr, input logic eclr);
        wel = w;
        start_cmd(K_WRP, a);
        for (int i = 0; i < n; i++) send_byte(seed + 8'(i * 7));
        end_frame(1'b1, tag, ewr, 1'b0, eclr);
        if (ewr) for (int i = 0; i < n; i++) model[8'(a[7:0] + i)] = seed + 8'(i * 7);
        wel = 1'b0;
    endtask

    task automatic verify_page(input logic [23:0] a, input int n, input string tag);
        start_cmd(K_RDP, a);
        for (int i = 0; i < n; i++) read_byte(tag, model[8'(a[7:0] + i)]);
        @(negedge clk); frame_end = 1'b1; frame_aligned = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic read_lock(input logic [23:0] a, input logic [7:0] exp, input string tag);
        start_cmd(K_RDL, a);
        read_byte(tag, exp);
        @(negedge clk); frame_end = 1'b1; frame_aligned = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic lock_frame(input logic [23:0] a, input logic w, input string tag,
                              input logic elk, input logic eclr);
        wel = w;
        start_cmd(K_LCK, a);
        send_byte(8'h5A);
        end_frame(1'b1, tag, 1'b0, elk, eclr);
        if (elk) model_lock = 1'b1;
        wel = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; nv_erase = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rd_valid in reset", {7'b0, rd_valid}, 8'h00);
        chk("R1 wel_clear in reset", {7'b0, wel_clear}, 8'h00);
        rst_n = 1'b1; nv_erase = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        model_lock = 1'b0;
        @(negedge clk);
        chk("R1 page_wr_req after reset", {7'b0, page_wr_req}, 8'h00);
        chk("R1 lock_prog_req after reset", {7'b0, lock_prog_req}, 8'h00);
        chk("R10 unlocked after erase", {7'b0, locked}, 8'h00);
        verify_page(24'h000010, 2, "R10 erased byte");
    endtask

    task automatic t_write_read;
        write_frame(24'h12B4F0, 20, 8'hA1, 1'b1, "R3 wrap write", 1'b1, 1'b1);
        verify_page(24'h0000EE, 24, "R3 readback");
        verify_page(24'hFFFFFE, 4, "R2 read wrap high addr");
        write_frame(24'h000040, 1, 8'h3C, 1'b1, "R3 single byte", 1'b1, 1'b1);
        verify_page(24'h000740, 1, "R2 upper bits ignored");
    endtask

    task automatic t_rejects;
        write_frame(24'h000080, 3, 8'h11, 1'b0, "R4 no wel", 1'b0, 1'b0);
        verify_page(24'h000080, 3, "R4 unchanged");
        wel = 1'b1;
        start_cmd(K_WRP, 24'h000090);
        send_byte(8'h77); send_byte(8'h78);
        end_frame(1'b0, "R5 misaligned", 1'b0, 1'b0, 1'b0);
        start_cmd(K_WRP, 24'h000090);
        end_frame(1'b1, "R5 no data byte", 1'b0, 1'b0, 1'b0);
        wel = 1'b0;
        verify_page(24'h000090, 2, "R5 unchanged");
    endtask

    task automatic t_lock;
        read_lock(24'h000400, 8'h00, "R6 unlocked A10=1");
        read_lock(24'h000000, 8'h00, "R6 unlocked A10=0");
        lock_frame(24'h000400, 1'b0, "R8 lock no wel", 1'b0, 1'b0);
        lock_frame(24'h000000, 1'b1, "R8 lock A10=0", 1'b0, 1'b0);
        chk("R8 still unlocked", {7'b0, locked}, 8'h00);
        lock_frame(24'h000400, 1'b1, "R7 lock accepted", 1'b1, 1'b1);
        chk("R7 locked", {7'b0, locked}, 8'h01);
        read_lock(24'hF0FC00, 8'h01, "R6 locked A10=1");
        read_lock(24'h0003FF, 8'h00, "R6 locked A10=0");
    endtask

    task automatic t_locked;
        write_frame(24'h0000F0, 4, 8'h20, 1'b1, "R9 write when locked", 1'b0, 1'b1);
        verify_page(24'h0000F0, 4, "R9 page unchanged");
        lock_frame(24'h000400, 1'b1, "R9 relock", 1'b0, 1'b1);
        chk("R9 still locked", {7'b0, locked}, 8'h01);
    endtask

    task automatic t_persist;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10 lock survives reset", {7'b0, locked}, 8'h01);
        verify_page(24'h0000F0, 4, "R10 page survives reset");
        @(negedge clk); nv_erase = 1'b1;
        @(negedge clk); nv_erase = 1'b0;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        chk("R10 erase unlocks", {7'b0, locked}, 8'h00);
        verify_page(24'h0000F2, 3, "R10 erased page");
    endtask

    initial begin
        rst_n = 1'b0; nv_erase = 1'b1; cmd_start = 1'b0; cmd_kind = 2'b00;
        cmd_addr = '0; dat_valid = 1'b0; dat_byte = '0; rd_req = 1'b0;
        frame_end = 1'b0; frame_aligned = 1'b1; wel = 1'b0;
        t_reset();
        t_write_read();
        t_rejects();
        t_lock();
        t_locked();
        t_persist();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule